// File: doc/BRIEF.md
# Burst ADC Capture Buffer Controller

This controller records a burst of conversions from a 16-bit parallel ADC into an on-chip buffer at the full sample rate. A slow host then reads the burst back one byte at a time. On the converter side it issues a conversion-start pulse for each sample. It waits for the converter's busy flag to rise and then fall, and then drives an active-low read strobe while it stores the word.

On the host side it takes a start command, a sample-rate tick, a read strobe, a byte select and a dedicated controller reset. All of these arrive asynchronously. Each one is synchronized into the local clock, and the pulse inputs are edge-detected.

A capture always fills the buffer completely before any readout is allowed. The host then steps through the stored words in capture order and picks the high or low byte of the current word. The buffer is an inferred simple dual-port memory of `DEPTH` words.

Top module: `burst_capture_ctrl`

## Requirements
- R1: After reset the controller sits idle; sample-rate ticks before a start command produce no conversion-start pulse.
- R2: Once started, each accepted tick produces exactly one conversion-start pulse, one clock wide; ticks arriving while a conversion is in progress are dropped.
- R3: The ADC read strobe (`adc_rd_n`, active low) goes low only after busy has been seen high and then low again following the conversion start, and it is never low in the same cycle as the conversion-start pulse.
- R4: The word present on `adc_data` while the read strobe is low is stored, and stored words keep their conversion order.
- R5: After `DEPTH` words are stored, acquisition stops: `buf_ready` goes to 1 and further ticks cause no conversion. The write pointer never exceeds `DEPTH`.
- R6: During readout, `host_data` shows bits [15:8] of the current word when `host_hi_sel` is 1, and bits [7:0] when it is 0. The first current word is the first sample of the burst, and `buf_empty` stays 0 while `buf_ready` is 1.
- R7: Each host read strobe advances the current word to the next stored sample.
- R8: A read strobe on the last stored word sets `buf_empty` to 1 and `buf_ready` to 0, and `host_data` keeps the last word. Later strobes change nothing.
- R9: A pulse on `host_sm_rst`, from any state, returns the controller to idle and discards the stored data (`buf_ready` 0, `buf_empty` 1). The next start records a fresh burst.
- R10: A start command received while `buf_ready` is 1 is ignored: no conversion starts and the readout position does not change.
- R11: A host pulse of any width (at least two clocks) causes exactly one action.
- R12: While `rst_n` is low, `adc_cnvst` is 0, `adc_rd_n` is 1, `buf_ready` is 0 and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Start-of-capture command (pulse) |
| host_tick | input | 1 | Sample-rate tick (pulse) |
| host_rd | input | 1 | Advance-to-next-word strobe (pulse) |
| host_hi_sel | input | 1 | 1 selects the high byte, 0 the low byte |
| host_sm_rst | input | 1 | Controller reset and buffer clear (pulse) |
| adc_busy | input | 1 | Converter busy flag |
| adc_data | input | 16 | Converter output word |
| adc_cnvst | output | 1 | Conversion-start pulse |
| adc_rd_n | output | 1 | Active-low converter read strobe |
| host_data | output | 8 | Selected byte of the current word |
| buf_ready | output | 1 | Buffer full, readout in progress |
| buf_empty | output | 1 | No unread words in the buffer |

## Verification
A wrong write pointer shows up at the ports in one of two ways. Either `buf_ready` rises after the wrong number of conversions, or the readout returns the burst shifted or with words repeated. Both are visible within one tick period of the fault or at the first byte read.

A read pointer that skips or stalls shows in `host_data` a few clocks after the strobe that caused it. A state machine that leaves the handshake order shows up as a read strobe while busy is high, or as a conversion that starts during readout, in the same cycle as the fault.

// File: rtl/burst_capture_ctrl.sv
module burst_capture_ctrl #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_start,
  input  logic        host_tick,
  input  logic        host_rd,
  input  logic        host_hi_sel,
  input  logic        host_sm_rst,
  input  logic        adc_busy,
  input  logic [15:0] adc_data,
  output logic        adc_cnvst,
  output logic        adc_rd_n,
  output logic [7:0]  host_data,
  output logic        buf_ready,
  output logic        buf_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_CONV, S_WHI, S_WLO, S_RD, S_WR, S_OUT
  } state_t;

  state_t state;
  logic [5:0] m1, m2;
  logic [3:0] prev;
  logic [PW-1:0] wptr, rptr;
  logic [15:0] mem [DEPTH];
  logic [15:0] rd_word;

  wire ev_start = m2[0] & ~prev[0];
  wire ev_tick  = m2[1] & ~prev[1];
  wire ev_rd    = m2[2] & ~prev[2];
  wire ev_srst  = m2[3] & ~prev[3];
  wire hi_s     = m2[4];
  wire busy_s   = m2[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1   <= '0;
      m2   <= '0;
      prev <= '0;
    end else begin
      m1   <= {adc_busy, host_hi_sel, host_sm_rst, host_rd, host_tick, host_start};
      m2   <= m1;
      prev <= m2[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wptr  <= '0;
      rptr  <= '0;
    end else if (ev_srst) begin
      state <= S_IDLE;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      case (state)
        S_IDLE: if (ev_start) begin
          wptr  <= '0;
          rptr  <= '0;
          state <= S_ARM;
        end
        S_ARM:  if (ev_tick) state <= S_CONV;
        S_CONV: state <= S_WHI;
        S_WHI:  if (busy_s) state <= S_WLO;
        S_WLO:  if (!busy_s) state <= S_RD;
        S_RD:   state <= S_WR;
        S_WR: begin
          wptr  <= wptr + 1'b1;
          state <= (wptr == PW'(DEPTH - 1)) ? S_OUT : S_ARM;
        end
        S_OUT: if (ev_rd) begin
          rptr <= rptr + 1'b1;
          if (rptr + 1'b1 == wptr) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_WR) mem[wptr[AW-1:0]] <= adc_data;
    if (rptr != wptr) rd_word <= mem[rptr[AW-1:0]];
  end

  assign adc_cnvst = (state == S_CONV);
  assign adc_rd_n  = !(state == S_RD || state == S_WR);
  assign host_data = hi_s ? rd_word[15:8] : rd_word[7:0];
  assign buf_ready = (state == S_OUT);
  assign buf_empty = (rptr == wptr);
endmodule

// File: rtl/burst_capture_chk.sv
module burst_capture_chk #(
  parameter int DEPTH = 1024,
  parameter int PW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_cnvst,
  input logic          adc_rd_n,
  input logic          adc_busy,
  input logic          buf_ready,
  input logic          buf_empty,
  input logic [PW-1:0] wptr
);
  assert_cnvst_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnvst |=> !adc_cnvst);

  assert_rd_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> !adc_busy);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnvst |-> adc_rd_n);

  assert_halt_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> (!adc_cnvst && adc_rd_n));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= PW'(DEPTH));

  assert_ready_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> !buf_empty);

  assert_release_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_ready) |-> buf_empty);
endmodule

bind burst_capture_ctrl burst_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cnvst(adc_cnvst), .adc_rd_n(adc_rd_n),
  .adc_busy(adc_busy), .buf_ready(buf_ready), .buf_empty(buf_empty), .wptr(wptr)
);

// File: tb/burst_capture_ctrl_tb.sv
module burst_capture_ctrl_tb;
  localparam int N = 8;
  localparam logic [15:0] VEC [N] = '{16'hA51C, 16'h3C7E, 16'h0001, 16'hFF80,
                                      16'h1234, 16'h8000, 16'h00FF, 16'hBEEF};

  logic clk = 0;
  logic rst_n = 0;
  logic host_start = 0, host_tick = 0, host_rd = 0, host_hi_sel = 0, host_sm_rst = 0;
  logic adc_busy = 0;
  logic [15:0] adc_data = 0;
  logic adc_cnvst, adc_rd_n, buf_ready, buf_empty;
  logic [7:0] host_data;
  int checks = 0, fails = 0, conv_n = 0, rd_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_capture_ctrl #(.DEPTH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_tick(host_tick),
    .host_rd(host_rd), .host_hi_sel(host_hi_sel), .host_sm_rst(host_sm_rst),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_cnvst(adc_cnvst),
    .adc_rd_n(adc_rd_n), .host_data(host_data), .buf_ready(buf_ready),
    .buf_empty(buf_empty)
  );

  initial forever begin
    @(negedge clk);
    if (adc_cnvst) begin
      adc_busy = 1;
      repeat (4) @(negedge clk);
      adc_data = VEC[conv_n % N];
      adc_busy = 0;
      conv_n++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (!adc_rd_n && adc_busy) rd_bad++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic p_start();
    host_start = 1; repeat (3) @(negedge clk); host_start = 0; repeat (8) @(negedge clk);
  endtask
  task automatic p_tick();
    host_tick = 1; repeat (3) @(negedge clk); host_tick = 0; repeat (30) @(negedge clk);
  endtask
  task automatic p_rd(input int w);
    host_rd = 1; repeat (w) @(negedge clk); host_rd = 0; repeat (8) @(negedge clk);
  endtask
  task automatic p_srst();
    host_sm_rst = 1; repeat (3) @(negedge clk); host_sm_rst = 0; repeat (8) @(negedge clk);
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 cnvst in reset", adc_cnvst, 0);
    chk("R12 rd_n in reset", adc_rd_n, 1);
    chk("R12 ready in reset", buf_ready, 0);
    chk("R12 empty in reset", buf_empty, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    p_tick(); p_tick();
    chk("R1 no conversion before start", conv_n, 0);
    p_start();
    chk("R1 start alone converts nothing", conv_n, 0);

    for (int i = 0; i < N; i++) begin
      p_tick();
      chk("R2 one conversion per tick", conv_n, i + 1);
      if (i < N - 1) chk("R5 not ready while filling", buf_ready, 0);
    end
    chk("R5 ready when full", buf_ready, 1);
    p_tick();
    chk("R5 tick ignored when full", conv_n, N);
    chk("R3 read strobe never during busy", rd_bad, 0);

    for (int i = 0; i < N; i++) begin
      host_hi_sel = 1; repeat (4) @(negedge clk);
      chk("R6 R4 high byte", host_data, VEC[i][15:8]);
      host_hi_sel = 0; repeat (4) @(negedge clk);
      chk("R6 R4 low byte", host_data, VEC[i][7:0]);
      if (i < N - 1) chk("R7 not empty mid readout", buf_empty, 0);
      p_rd(3);
    end
    chk("R8 empty after last word", buf_empty, 1);
    chk("R8 ready dropped", buf_ready, 0);
    chk("R8 last word held", host_data, VEC[N-1][7:0]);
    p_rd(3);
    chk("R8 extra strobe no effect", host_data, VEC[N-1][7:0]);

    p_start();
    for (int i = 0; i < N; i++) p_tick();
    chk("R5 second burst full", buf_ready, 1);
    p_rd(40);
    chk("R11 long strobe advances once", host_data, VEC[1][7:0]);
    p_start();
    p_tick();
    chk("R10 start in readout no conversion", conv_n, 2 * N);
    chk("R10 still ready", buf_ready, 1);
    chk("R10 position unchanged", host_data, VEC[1][7:0]);
    p_rd(3);
    chk("R7 advance to next word", host_data, VEC[2][7:0]);

    p_srst();
    chk("R9 reset clears ready", buf_ready, 0);
    chk("R9 reset sets empty", buf_empty, 1);
    p_start();
    for (int i = 0; i < 3; i++) p_tick();
    p_srst();
    chk("R9 reset mid capture empty", buf_empty, 1);
    p_tick();
    chk("R9 idle after reset", conv_n, 2 * N + 3);
    p_start();
    for (int i = 0; i < N; i++) p_tick();
    chk("R9 fresh burst full", buf_ready, 1);
    chk("R9 fresh burst first word", host_data, VEC[(2 * N + 3) % N][7:0]);

    finish_run();
  end
endmodule